// File: doc/BRIEF.md
# Luma and RGB Gain Stage

This block sits in a video encoder's pixel pipeline and scales picture levels before synchronisation and modulation are added. Each cycle it takes three 10-bit components and a format flag. When the flag marks YCbCr data, only the luminance component is scaled, by one of sixteen fixed factors chosen by a 4-bit level code. The two colour-difference components come out unchanged. When the flag marks RGB data, each of the three channels is multiplied by its own 8-bit gain, which runs from zero up to just under double.

The level code and the three channel gains are static settings held by registers elsewhere in the chip. They are sampled together with each pixel, so a change takes effect on a pixel boundary. Products are rounded to the nearest integer and clipped to the 10-bit range. Results appear two clock cycles after the pixel is presented, with a valid flag that travels with the data.

Top module: `video_gain_stage`

## Requirements
- R1: In YCbCr mode (`in_is_rgb` = 0) `out_c0` equals `in_c0 * (25 + luma_code) / 32`, so code 0 is a gain of 0.78125, code 15 is 1.25, each step adds 0.03125, and code 7 is exactly unity.
- R2: In YCbCr mode `out_c1` and `out_c2` equal `in_c1` and `in_c2` of the same pixel, bit for bit.
- R3: In RGB mode (`in_is_rgb` = 1), lane c0 carries G, lane c1 carries B and lane c2 carries R. Each lane's output is its input times its own gain divided by 128 (`gain_g`, `gain_b` and `gain_r` respectively), so a gain of 128 is unity and a gain of 0 forces zero.
- R4: The division is rounded to nearest, and an exact half rounds up (for example Y = 16 with code 0 gives 12.5, which becomes 13).
- R5: Any result above 1023 is clipped to 1023.
- R6: Latency is exactly two cycles. `out_valid` repeats `in_valid` delayed by two cycles, and the outputs belong to the pixel presented two cycles earlier.
- R7: While reset is held and just after it is released, `out_valid` is 0 and all three output components are 0.
- R8: The level code has no effect in RGB mode, and the three channel gains have no effect in YCbCr mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_is_rgb | input | 1 | 1: RGB pixel, 0: YCbCr pixel |
| in_c0 | input | 10 | Y or G component |
| in_c1 | input | 10 | Cb or B component |
| in_c2 | input | 10 | Cr or R component |
| luma_code | input | 4 | Luminance level code |
| gain_g | input | 8 | Green gain, unity at 128 |
| gain_b | input | 8 | Blue gain, unity at 128 |
| gain_r | input | 8 | Red gain, unity at 128 |
| out_valid | output | 1 | Output pixel qualifier |
| out_c0 | output | 10 | Scaled Y or G |
| out_c1 | output | 10 | Cb (passed) or scaled B |
| out_c2 | output | 10 | Cr (passed) or scaled R |

## Verification
The hardest cases to reach are exact half-way products, where rounding direction decides the result, and results that land just above the clip point. Uniform random pixels rarely hit either of these. The stimulus therefore adds directed pixels whose products leave a remainder of exactly one half, and pixels near full scale with the top level code or large gains. The format flag and every gain also change from pixel to pixel, so that a setting leaking into the wrong mode or the wrong pipeline slot would show up in the outputs.

// File: rtl/gain_pkg.sv
`timescale 1ns/1ps
package gain_pkg;
  localparam int PIX_W       = 10;
  localparam int LUMA_CODE_W = 4;
  localparam int CH_GAIN_W   = 8;
  localparam int LUMA_BASE   = 25;
  localparam int LUMA_FRAC   = 5;
  localparam int CH_FRAC     = 7;
  localparam int NUM_LANES   = 3;

  typedef enum logic {FMT_YCBCR = 1'b0, FMT_RGB = 1'b1} fmt_e;

  typedef struct packed {
    logic [CH_GAIN_W-1:0] factor;
    logic                 wide_frac;
  } lane_cfg_t;
endpackage

// File: rtl/gain_cfg_sel.sv
`timescale 1ns/1ps
module gain_cfg_sel
  import gain_pkg::*;
#(
  parameter int CODE_W = LUMA_CODE_W,
  parameter int GAIN_W = CH_GAIN_W,
  parameter int LANES  = NUM_LANES
) (
  input  logic                   is_rgb,
  input  logic [CODE_W-1:0]      luma_code,
  input  logic [GAIN_W-1:0]      gain_g,
  input  logic [GAIN_W-1:0]      gain_b,
  input  logic [GAIN_W-1:0]      gain_r,
  output lane_cfg_t [LANES-1:0]  cfg
);
  localparam logic [GAIN_W-1:0] UNITY_WIDE = GAIN_W'(1) << CH_FRAC;

  function automatic logic [GAIN_W-1:0] luma_factor(input logic [CODE_W-1:0] code);
    return GAIN_W'(LUMA_BASE) + GAIN_W'(code);
  endfunction

  logic [GAIN_W-1:0] ch_gain [LANES];
  always_comb begin
    ch_gain[0] = gain_g;
    ch_gain[1] = gain_b;
    ch_gain[2] = gain_r;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_cfg
    always_comb begin
      if (fmt_e'(is_rgb) == FMT_RGB) begin
        cfg[l].factor    = ch_gain[l];
        cfg[l].wide_frac = 1'b1;
      end else if (l == 0) begin
        cfg[l].factor    = luma_factor(luma_code);
        cfg[l].wide_frac = 1'b0;
      end else begin
        cfg[l].factor    = UNITY_WIDE;
        cfg[l].wide_frac = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gain_lane.sv
`timescale 1ns/1ps
module gain_lane #(
  parameter int DW          = 10,
  parameter int FW          = 8,
  parameter int NARROW_FRAC = 5,
  parameter int WIDE_FRAC   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_data,
  input  logic [FW-1:0] in_factor,
  input  logic          in_wide,
  output logic [DW-1:0] out_data,
  output logic          clip_hit
);
  localparam int PW = DW + FW;
  localparam logic [PW:0] HALF_N = (PW+1)'(1) << (NARROW_FRAC - 1);
  localparam logic [PW:0] HALF_W = (PW+1)'(1) << (WIDE_FRAC - 1);
  localparam logic [PW:0] TOP    = (PW+1)'((1 << DW) - 1);

  function automatic logic [PW:0] round_shift(input logic [PW-1:0] p, input logic wide);
    logic [PW:0] s;
    s = {1'b0, p} + (wide ? HALF_W : HALF_N);
    return wide ? (s >> WIDE_FRAC) : (s >> NARROW_FRAC);
  endfunction

  logic [PW-1:0] prod_q;
  logic          wide_q;
  logic [PW:0]   rounded;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q <= '0;
      wide_q <= 1'b0;
    end else begin
      prod_q <= PW'(in_data) * PW'(in_factor);
      wide_q <= in_wide;
    end
  end

  always_comb begin
    rounded  = round_shift(prod_q, wide_q);
    clip_hit = rounded > TOP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_data <= '0;
    else        out_data <= clip_hit ? DW'(TOP) : rounded[DW-1:0];
  end
endmodule

// File: rtl/video_gain_stage.sv
`timescale 1ns/1ps
module video_gain_stage
  import gain_pkg::*;
#(
  parameter int DW     = PIX_W,
  parameter int CODE_W = LUMA_CODE_W,
  parameter int GAIN_W = CH_GAIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_is_rgb,
  input  logic [DW-1:0]     in_c0,
  input  logic [DW-1:0]     in_c1,
  input  logic [DW-1:0]     in_c2,
  input  logic [CODE_W-1:0] luma_code,
  input  logic [GAIN_W-1:0] gain_g,
  input  logic [GAIN_W-1:0] gain_b,
  input  logic [GAIN_W-1:0] gain_r,
  output logic              out_valid,
  output logic [DW-1:0]     out_c0,
  output logic [DW-1:0]     out_c1,
  output logic [DW-1:0]     out_c2
);
  localparam int LANES = NUM_LANES;

  lane_cfg_t [LANES-1:0] cfg;
  logic [DW-1:0] lane_in  [LANES];
  logic [DW-1:0] lane_out [LANES];
  logic [LANES-1:0] lane_clip;
  logic valid_q;

  gain_cfg_sel #(.CODE_W(CODE_W), .GAIN_W(GAIN_W), .LANES(LANES)) u_cfg (
    .is_rgb(in_is_rgb), .luma_code(luma_code),
    .gain_g(gain_g), .gain_b(gain_b), .gain_r(gain_r), .cfg(cfg)
  );

  always_comb begin
    lane_in[0] = in_c0;
    lane_in[1] = in_c1;
    lane_in[2] = in_c2;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    gain_lane #(.DW(DW), .FW(GAIN_W), .NARROW_FRAC(LUMA_FRAC), .WIDE_FRAC(CH_FRAC)) u_lane (
      .clk(clk), .rst_n(rst_n), .in_data(lane_in[l]),
      .in_factor(cfg[l].factor), .in_wide(cfg[l].wide_frac),
      .out_data(lane_out[l]), .clip_hit(lane_clip[l])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      valid_q   <= in_valid;
      out_valid <= valid_q;
    end
  end

  assign out_c0 = lane_out[0];
  assign out_c1 = lane_out[1];
  assign out_c2 = lane_out[2];
endmodule

// File: rtl/video_gain_stage_chk.sv
`timescale 1ns/1ps
module video_gain_stage_chk
  import gain_pkg::*;
#(
  parameter int DW     = PIX_W,
  parameter int CODE_W = LUMA_CODE_W,
  parameter int GAIN_W = CH_GAIN_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_is_rgb,
  input logic [DW-1:0]     in_c0,
  input logic [DW-1:0]     in_c1,
  input logic [DW-1:0]     in_c2,
  input logic [CODE_W-1:0] luma_code,
  input logic [GAIN_W-1:0] gain_g,
  input logic [GAIN_W-1:0] gain_r,
  input logic              out_valid,
  input logic [DW-1:0]     out_c0,
  input logic [DW-1:0]     out_c1,
  input logic [DW-1:0]     out_c2
);
  localparam logic [CODE_W-1:0] UNITY_CODE = CODE_W'((1 << LUMA_FRAC) - LUMA_BASE);
  localparam logic [GAIN_W-1:0] UNITY_GAIN = GAIN_W'(1) << CH_FRAC;

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 2));

  p_chroma_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(in_is_rgb, 2)) |->
      (out_c1 == $past(in_c1, 2) && out_c2 == $past(in_c2, 2)));

  p_luma_unity_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(in_is_rgb, 2) && $past(luma_code, 2) == UNITY_CODE) |->
      out_c0 == $past(in_c0, 2));

  p_green_unity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_is_rgb, 2) && $past(gain_g, 2) == UNITY_GAIN) |->
      out_c0 == $past(in_c0, 2));

  p_red_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_is_rgb, 2) && $past(gain_r, 2) == '0) |->
      out_c2 == '0);

  p_reset_quiet_r7: assert property (@(posedge clk)
    $past(!rst_n) |-> (!out_valid && out_c0 == '0 && out_c1 == '0 && out_c2 == '0));
endmodule

bind video_gain_stage video_gain_stage_chk #(.DW(DW), .CODE_W(CODE_W), .GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_rgb(in_is_rgb),
  .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2), .luma_code(luma_code),
  .gain_g(gain_g), .gain_r(gain_r), .out_valid(out_valid),
  .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
);

// File: tb/video_gain_stage_bench.sv
`timescale 1ns/1ps
module video_gain_stage_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_is_rgb = 1'b0;
  logic [9:0] in_c0 = '0, in_c1 = '0, in_c2 = '0;
  logic [3:0] luma_code = '0;
  logic [7:0] gain_g = '0, gain_b = '0, gain_r = '0;
  logic out_valid;
  logic [9:0] out_c0, out_c1, out_c2;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  video_gain_stage u_video_gain_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_rgb(in_is_rgb),
    .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2), .luma_code(luma_code),
    .gain_g(gain_g), .gain_b(gain_b), .gain_r(gain_r),
    .out_valid(out_valid), .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
  );

  function automatic int ref_luma(int y, int code);
    int v = (y * (25 + code) + 16) / 32;
    return (v > 1023) ? 1023 : v;
  endfunction

  function automatic int ref_chan(int x, int g);
    int v = (x * g + 64) / 128;
    return (v > 1023) ? 1023 : v;
  endfunction

  function automatic bit would_clip_luma(int y, int code);
    return ((y * (25 + code) + 16) / 32) > 1023;
  endfunction

  function automatic bit would_clip_chan(int x, int g);
    return ((x * g + 64) / 128) > 1023;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // expected results for the two pixels in flight
  bit    p1_v, p2_v;
  int    p1_e [3], p2_e [3];
  string p1_t [3], p2_t [3];

  task automatic step(bit v, bit rgb, int c0, int c1, int c2, int code,
                      int gg, int gb, int gr, string force_tag);
    @(negedge clk);
    check("R6", "out_valid", int'(out_valid), int'(p2_v));
    if (p2_v) begin
      check(p2_t[0], "out_c0", int'(out_c0), p2_e[0]);
      check(p2_t[1], "out_c1", int'(out_c1), p2_e[1]);
      check(p2_t[2], "out_c2", int'(out_c2), p2_e[2]);
    end
    p2_v = p1_v;
    for (int k = 0; k < 3; k++) begin
      p2_e[k] = p1_e[k];
      p2_t[k] = p1_t[k];
    end
    p1_v = v;
    if (rgb) begin
      p1_e[0] = ref_chan(c0, gg); p1_t[0] = would_clip_chan(c0, gg) ? "R5" : "R3";
      p1_e[1] = ref_chan(c1, gb); p1_t[1] = would_clip_chan(c1, gb) ? "R5" : "R3";
      p1_e[2] = ref_chan(c2, gr); p1_t[2] = would_clip_chan(c2, gr) ? "R5" : "R3";
    end else begin
      p1_e[0] = ref_luma(c0, code); p1_t[0] = would_clip_luma(c0, code) ? "R5" : "R1";
      p1_e[1] = c1; p1_t[1] = "R2";
      p1_e[2] = c2; p1_t[2] = "R2";
    end
    if (force_tag != "")
      for (int k = 0; k < 3; k++) p1_t[k] = force_tag;
    in_valid  = v;
    in_is_rgb = rgb;
    in_c0 = 10'(c0); in_c1 = 10'(c1); in_c2 = 10'(c2);
    luma_code = 4'(code);
    gain_g = 8'(gg); gain_b = 8'(gb); gain_r = 8'(gr);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_0017;
    void'($urandom(seed));
    p1_v = 0; p2_v = 0;
    for (int k = 0; k < 3; k++) begin p1_e[k] = 0; p2_e[k] = 0; p1_t[k] = ""; p2_t[k] = ""; end
    repeat (4) @(negedge clk);
    // R7: outputs quiet while reset is held
    check("R7", "out_valid in reset", int'(out_valid), 0);
    check("R7", "out_c0 in reset", int'(out_c0), 0);
    check("R7", "out_c1 in reset", int'(out_c1), 0);
    check("R7", "out_c2 in reset", int'(out_c2), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", "out_valid after reset", int'(out_valid), 0);

    // R1: extremes and unity of the level code
    step(1, 0, 640, 100, 900, 0,  0, 0, 0, "R1");
    step(1, 0, 640, 101, 901, 15, 0, 0, 0, "R1");
    step(1, 0, 333, 512, 64,  7,  0, 0, 0, "R1");
    // R4: exact halves round up (16*25=400 -> 12.5 -> 13)
    step(1, 0, 16, 0, 0, 0, 0, 0, 0, "R4");
    step(1, 1, 1, 3, 5, 0, 64, 64, 64, "R4");
    // R5: clip at full scale
    step(1, 0, 1023, 0, 1023, 15, 0, 0, 0, "R5");
    step(1, 1, 1023, 1023, 1023, 0, 255, 200, 130, "R5");
    // R3: unity and zero gains per lane
    step(1, 1, 777, 555, 333, 3, 128, 0, 128, "R3");
    step(1, 1, 777, 555, 333, 3, 0, 128, 1, "R3");
    // R8: gains ignored in YCbCr mode, level code ignored in RGB mode
    step(1, 0, 500, 600, 700, 7, 255, 0, 17, "R8");
    step(1, 0, 500, 600, 700, 7, 3, 250, 99, "R8");
    step(1, 1, 400, 401, 402, 0, 77, 150, 200, "R8");
    step(1, 1, 400, 401, 402, 15, 77, 150, 200, "R8");
    // R6: bubbles in the stream
    step(0, 0, 1, 2, 3, 4, 5, 6, 7, "R6");
    step(1, 0, 10, 20, 30, 9, 0, 0, 0, "");
    step(0, 1, 9, 9, 9, 9, 9, 9, 9, "R6");

    for (int i = 0; i < 3000; i++) begin
      bit v, rgb;
      int c0, c1, c2, gg, gb, gr;
      v   = ($urandom % 8) != 0;
      rgb = $urandom % 2;
      c0  = ($urandom % 4 == 0) ? 900 + $urandom % 124 : $urandom % 1024;
      c1  = $urandom % 1024;
      c2  = $urandom % 1024;
      gg  = ($urandom % 4 == 0) ? 200 + $urandom % 56 : $urandom % 256;
      gb  = $urandom % 256;
      gr  = $urandom % 256;
      step(v, rgb, c0, c1, c2, $urandom % 16, gg, gb, gr, "");
    end
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule